// File: doc/BRIEF.md
# Pseudo-Random RAM Filler

This peripheral loads a 255-entry, 8-bit data RAM with a pseudo-random byte sequence. The sequence comes from an 8-bit linear congruential generator, a fixed-constant recurrence that yields one new byte every clock cycle. While a run is in progress, the block drives the shared RAM write port and stores each byte at its own running index, so the whole RAM is filled in 255 consecutive cycles.

The processor starts a run by writing a control register with its initialize bit set. It then polls a status register until the completion flag rises. Outside a run, the processor's own RAM write port passes straight through the block's multiplexer to the RAM. During a run, the processor's RAM writes are shut out.

Top module: `lcg_fill`

## Requirements
- R1: After reset the status byte reads 0x00 and the block does not drive a RAM write on its own.
- R2: While no run is in progress, the RAM address, data and write enable equal the processor's RAM address, data and write enable in the same cycle.
- R3: A control write with its bit 0 equal to 1 starts a run. In the cycle after that write, the RAM port shows write enable 1, address 0x00 and data 0xD7 (the seed).
- R4: During a run, each cycle's data equals (0x11 × previous data + 0x9D) mod 256, using unsigned arithmetic.
- R5: During a run, the address rises by one each cycle from 0x00 to 0xFE. Write enable is high for exactly 255 consecutive cycles and is low after that.
- R6: During a run, processor RAM writes have no effect on the RAM port outputs.
- R7: The status byte has the completion flag in bit 0 and zeros elsewhere. The flag reads 1 in the cycle after the write to address 0xFE and stays 1 until a control write.
- R8: Any control write, whatever its bit 0, makes the completion flag read 0 in the next cycle. This holds even when the write falls on the last cycle of a run.
- R9: A control write with bit 0 equal to 1 during a run restarts the run from address 0x00 and the seed.
- R10: A control write with bit 0 equal to 0 during a run leaves the run's addresses and data undisturbed.
- R11: The 255 bytes written in one run are all different.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWe | input | 1 | Processor write strobe for the control register |
| ctrlInitBit | input | 1 | Bit 0 of the written control byte (1 = start a run) |
| statusData | output | 8 | Status byte; bit 0 is the completion flag |
| cpuRamAddr | input | 8 | Processor RAM address |
| cpuRamData | input | 8 | Processor RAM write data |
| cpuRamWe | input | 1 | Processor RAM write enable |
| ramAddr | output | 8 | RAM address after the multiplexer |
| ramData | output | 8 | RAM write data after the multiplexer |
| ramWe | output | 1 | RAM write enable after the multiplexer |

## Verification
The bench builds the block with its default parameters: 8-bit data, 255 entries and the fixed constants. At this size a single run covers every index and nearly the whole period of the generator. The bench therefore compares all 255 address and data pairs against a recurrence it computes itself, and it checks that no value repeats. Control writes are placed mid-run, on the final cycle, and while the block is idle, which exercises the restart, the undisturbed run and the precedence of clearing the flag over setting it.

// File: rtl/lcg_fill_pkg.sv
package lcg_fill_pkg;
  typedef struct packed {
    logic load;   // reload seed and zero the index
    logic step;   // advance generator and index
  } fillStrobes_t;
endpackage

// File: rtl/lcg_fill_dpath.sv
module lcg_fill_dpath
  import lcg_fill_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COUNT  = 255,
  parameter logic [DATA_W-1:0] MULT = 8'h11,
  parameter logic [DATA_W-1:0] INC  = 8'h9D,
  parameter logic [DATA_W-1:0] SEED = 8'hD7,
  localparam int ADDR_W = $clog2(COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobes_t      strobes,
  output logic [DATA_W-1:0] valOut,
  output logic [ADDR_W-1:0] idxOut,
  output logic              lastIdx
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(COUNT - 1);

  logic [DATA_W-1:0] valQ;
  logic [ADDR_W-1:0] idxQ;
  logic [DATA_W-1:0] nextVal;

  assign nextVal = valQ * MULT + INC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ <= SEED;
      idxQ <= '0;
    end else if (strobes.load) begin
      valQ <= SEED;
      idxQ <= '0;
    end else if (strobes.step) begin
      valQ <= nextVal;
      idxQ <= idxQ + 1'b1;
    end
  end

  assign valOut  = valQ;
  assign idxOut  = idxQ;
  assign lastIdx = (idxQ == LAST);

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (valQ == SEED && idxQ == '0)); // R3
  AST_RECURRENCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> (valQ == DATA_W'($past(valQ) * MULT + INC))); // R4
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> (idxQ == $past(idxQ) + 1'b1)); // R5
endmodule

// File: rtl/lcg_fill_ctrl.sv
module lcg_fill_ctrl
  import lcg_fill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWe,
  input  logic         ctrlInitBit,
  input  logic         lastIdx,
  output fillStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  logic busyQ, doneQ;
  logic startReq, finishing;

  assign startReq  = ctrlWe && ctrlInitBit;
  assign finishing = busyQ && lastIdx && !startReq;

  always_comb begin
    strobes.load = startReq;
    strobes.step = busyQ && !startReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      if (startReq)       busyQ <= 1'b1;
      else if (finishing) busyQ <= 1'b0;

      if (ctrlWe)         doneQ <= 1'b0;
      else if (finishing) doneQ <= 1'b1;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(busyQ)); // R7
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> !doneQ); // R8
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busyQ); // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busyQ && doneQ)); // R7
endmodule

// File: rtl/lcg_fill.sv
module lcg_fill
  import lcg_fill_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COUNT  = 255,
  parameter logic [DATA_W-1:0] MULT = 8'h11,
  parameter logic [DATA_W-1:0] INC  = 8'h9D,
  parameter logic [DATA_W-1:0] SEED = 8'hD7,
  localparam int ADDR_W = $clog2(COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic              ctrlInitBit,
  output logic [DATA_W-1:0] statusData,
  input  logic [ADDR_W-1:0] cpuRamAddr,
  input  logic [DATA_W-1:0] cpuRamData,
  input  logic              cpuRamWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              ramWe
);
  fillStrobes_t      strobes;
  logic              lastIdx, busy, done;
  logic [DATA_W-1:0] genVal;
  logic [ADDR_W-1:0] genIdx;

  lcg_fill_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlInitBit(ctrlInitBit),
    .lastIdx(lastIdx), .strobes(strobes), .busy(busy), .done(done)
  );

  lcg_fill_dpath #(
    .DATA_W(DATA_W), .COUNT(COUNT), .MULT(MULT), .INC(INC), .SEED(SEED)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .valOut(genVal), .idxOut(genIdx), .lastIdx(lastIdx)
  );

  always_comb begin
    if (busy) begin
      ramAddr = genIdx;
      ramData = genVal;
      ramWe   = 1'b1;
    end else begin
      ramAddr = cpuRamAddr;
      ramData = cpuRamData;
      ramWe   = cpuRamWe;
    end
  end

  assign statusData = {{(DATA_W-1){1'b0}}, done};

  AST_FILL_ADDR_START: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlInitBit) |=> (ramWe && ramAddr == '0)); // R3
  AST_FILL_OWNS_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpuRamWe) |-> (ramAddr == genIdx)); // R6
endmodule

// File: tb/lcg_fill_test.sv
module lcg_fill_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic       ctrlInitBit = 1'b0;
  logic [7:0] statusData;
  logic [7:0] cpuRamAddr = 8'h00;
  logic [7:0] cpuRamData = 8'h00;
  logic       cpuRamWe = 1'b0;
  logic [7:0] ramAddr;
  logic [7:0] ramData;
  logic       ramWe;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit seen [256];

  always #10 clk = ~clk;

  lcg_fill uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlInitBit(ctrlInitBit),
    .statusData(statusData), .cpuRamAddr(cpuRamAddr), .cpuRamData(cpuRamData),
    .cpuRamWe(cpuRamWe), .ramAddr(ramAddr), .ramData(ramData), .ramWe(ramWe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ctrlWrite(input logic bit0);
    ctrlWe = 1'b1;
    ctrlInitBit = bit0;
    tick();
    ctrlWe = 1'b0;
    ctrlInitBit = 1'b0;
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] v);
    return 8'((32'(v) * 32'h11 + 32'h9D) % 256);
  endfunction

  initial begin
    int distinct;
    logic [7:0] exp;
    #5;
    // R1: reset state
    check("R1 status", 32'(statusData), 0);
    check("R1 we", 32'(ramWe), 0);
    rstN = 1'b1;
    tick();
    check("R1 status after reset", 32'(statusData), 0);
    // R2: passthrough sweep
    for (int a = 0; a < 256; a += 17) begin
      cpuRamAddr = 8'(a); cpuRamData = 8'(255 - a); cpuRamWe = a[0];
      #1;
      check("R2 addr", 32'(ramAddr), 32'(a));
      check("R2 data", 32'(ramData), 32'(255 - a));
      check("R2 we", 32'(ramWe), 32'(a[0]));
    end
    cpuRamWe = 1'b0;
    // Run 1: full run with processor writes and a non-init control write mid-run
    ctrlWrite(1'b1);
    exp = 8'hD7;
    check("R3 first data", 32'(ramData), 32'hD7);
    distinct = 0;
    for (int i = 0; i < 255; i++) begin
      if (i == 20) begin
        cpuRamWe = 1'b1; cpuRamAddr = 8'h55; cpuRamData = 8'h33; #1;
      end
      if (i == 21) cpuRamWe = 1'b0;
      check("R5 we", 32'(ramWe), 1);
      check("R5 R6 addr", 32'(ramAddr), 32'(i));
      check("R4 R6 data", 32'(ramData), 32'(exp));
      check("R7 done low during run", 32'(statusData), 0);
      if (!seen[ramData]) distinct++;
      seen[ramData] = 1'b1;
      exp = nxt(exp);
      if (i == 100) ctrlWrite(1'b0); // R10
      else tick();
    end
    check("R11 distinct", 32'(distinct), 255);
    check("R5 we ends", 32'(ramWe), 0);
    check("R7 done set", 32'(statusData), 1);
    tick(); tick();
    check("R7 done holds", 32'(statusData), 1);
    ctrlWrite(1'b0);
    check("R8 idle clear", 32'(statusData), 0);
    check("R8 no run", 32'(ramWe), 0);
    // Run 2: restart mid-run (R9)
    ctrlWrite(1'b1);
    for (int i = 0; i < 10; i++) tick();
    check("R9 mid addr", 32'(ramAddr), 10);
    ctrlWrite(1'b1);
    check("R9 restart addr", 32'(ramAddr), 0);
    check("R9 restart data", 32'(ramData), 32'hD7);
    // run to last cycle, write non-init there (R8 precedence)
    for (int i = 0; i < 254; i++) tick();
    check("R5 last addr", 32'(ramAddr), 32'hFE);
    ctrlWrite(1'b0);
    check("R8 clear wins", 32'(statusData), 0);
    check("R8 run ended", 32'(ramWe), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule